// File: doc/BRIEF.md
# Line Phase-Loss Monitor

This block supervises the mains phase input of a ground-fault controller. Every rising edge on the phase input restarts an age counter kept in milliseconds. When the counter runs past the timeout, the monitor decides that the line clock is lost and raises a no-clock alarm. While the alarm is active, the block drives its own cadence on the indicator LED and on the SCR gate. It takes half-cycle polarity from an alternate zero-cross strobe supplied by the bias circuitry, because the phase input is gone.

The alarm clears only when phase activity clearly returns. A single stray pulse is not enough: the block needs two rising edges less than the timeout apart. After recovery, it waits a fixed delay and then asks the surrounding logic for one self-test. It counts consecutive failed results of these tests. Enough failures in a row latch an end-of-life flag that only reset clears.

All timing comes from a one-cycle `tick1ms` strobe. Every interval is a parameter expressed in ticks.

Top module: `phase_loss_monitor`

## Requirements
- R1: After reset, noClock, ledOn, scrGate, stReq and stEol are all low.
- R2: noClock rises once more than 32 ticks pass with no rising edge on phaseIn, counted from the last edge or from reset. It stays low at 30 ticks after that point.
- R3: ledOn is low for the first 150 ticks of the no-clock state. After that it alternates, high for 125 ticks and then low for 125 ticks, starting high. It is never high outside the no-clock state.
- R4: In the no-clock state, a gate request comes due every 4000 ticks after entry. The half-cycle polarity starts negative at entry and flips on every zcStrobe pulse. A due request makes scrGate go high at the next strobe that starts a positive half. scrGate stays high for exactly one strobe interval. One request gives one gate.
- R5: A rising edge on phaseIn clears the no-clock state only if an earlier edge was seen in that state no more than 32 ticks before it. A lone edge, or an edge that follows the previous one by more than 32 ticks, leaves noClock high. When the state clears, ledOn and scrGate are low.
- R6: stReq is a one-cycle pulse that comes 75 ticks after the no-clock state clears.
- R7: A test result is a cycle with stDone high. stPass high means pass and low means fail. Four consecutive failed results set stEol, and stEol stays high until reset.
- R8: A passing result sets the consecutive-failure count back to zero.
- R9: zcStrobe has no effect outside the no-clock state: scrGate stays low there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick1ms | input | 1 | One-cycle pulse per millisecond |
| phaseIn | input | 1 | Raw mains phase input; synchronized inside |
| zcStrobe | input | 1 | One-cycle pulse per zero crossing from the bias circuitry |
| stDone | input | 1 | Self-test result valid |
| stPass | input | 1 | Self-test result, 1 = pass |
| noClock | output | 1 | Phase-loss alarm state |
| ledOn | output | 1 | Indicator LED drive |
| scrGate | output | 1 | SCR gate drive |
| stReq | output | 1 | One-cycle self-test request |
| stEol | output | 1 | Sticky end-of-life flag |

## Verification
Faults in the edge-age counter or the recovery qualifier show up first on noClock. They appear within a few milliseconds of the 32-tick boundary, or on the edge that should or should not clear the alarm. Faults in the cadence counters show up as ledOn at the wrong millisecond offsets, or as a wrong count or width of scrGate pulses over a window of about 8.6 s. Faults in the result counter show up only after the fourth failed round, as a wrong stEol level.

// File: rtl/plm_pkg.sv
package plm_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_NOCLK   = 2'd1,
    ST_RESTART = 2'd2
  } plmState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic nocRun;    // no-clock cadence counters enabled
    logic delayRun;  // post-recovery delay counter enabled
  } plmStrobes_t;
endpackage

// File: rtl/plm_datapath.sv
module plm_datapath
  import plm_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int TIMEOUT_MS    = 32,
  parameter int LED_DELAY_MS  = 150,
  parameter int BLINK_HALF_MS = 125,
  parameter int SCR_PERIOD_MS = 4000,
  parameter int RESTART_MS    = 75
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick1ms,
  input  logic        phaseIn,
  input  plmStrobes_t strobes,
  output logic        phaseRise,
  output logic        ageExpired,
  output logic        scrDue,
  output logic        delayDone,
  output logic        ledOn
);
  localparam int AGE_W   = $clog2(TIMEOUT_MS + 2);
  localparam int NOC_W   = $clog2(LED_DELAY_MS + 1);
  localparam int BLINK_W = $clog2(2 * BLINK_HALF_MS);
  localparam int SCR_W   = $clog2(SCR_PERIOD_MS);
  localparam int DLY_W   = $clog2(RESTART_MS + 1);

  localparam logic [AGE_W-1:0]   AGE_MAX    = AGE_W'(TIMEOUT_MS + 1);
  localparam logic [NOC_W-1:0]   LED_START  = NOC_W'(LED_DELAY_MS);
  localparam logic [BLINK_W-1:0] BLINK_HALF = BLINK_W'(BLINK_HALF_MS);
  localparam logic [BLINK_W-1:0] BLINK_LAST = BLINK_W'(2 * BLINK_HALF_MS - 1);
  localparam logic [SCR_W-1:0]   SCR_LAST   = SCR_W'(SCR_PERIOD_MS - 1);
  localparam logic [DLY_W-1:0]   DLY_END    = DLY_W'(RESTART_MS);

  // synchronizer plus one delayed stage for edge detection
  logic [SYNC_STAGES:0] syncPipe;
  always_ff @(posedge clk) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[SYNC_STAGES-1:0], phaseIn};
  end
  assign phaseRise = syncPipe[SYNC_STAGES-1] & ~syncPipe[SYNC_STAGES];

  // milliseconds since the last rising edge, saturating one past the timeout
  logic [AGE_W-1:0] edgeAge;
  always_ff @(posedge clk) begin
    if (!rstN)                             edgeAge <= '0;
    else if (phaseRise)                    edgeAge <= '0;
    else if (tick1ms && edgeAge != AGE_MAX) edgeAge <= edgeAge + 1'b1;
  end
  assign ageExpired = (edgeAge == AGE_MAX);

  // LED start delay after no-clock entry
  logic [NOC_W-1:0] nocAge;
  logic             ledArmed;
  always_ff @(posedge clk) begin
    if (!rstN || !strobes.nocRun)          nocAge <= '0;
    else if (tick1ms && nocAge != LED_START) nocAge <= nocAge + 1'b1;
  end
  assign ledArmed = (nocAge == LED_START);

  // blink phase counter
  logic [BLINK_W-1:0] blinkCnt;
  always_ff @(posedge clk) begin
    if (!rstN || !strobes.nocRun || !ledArmed) blinkCnt <= '0;
    else if (tick1ms) blinkCnt <= (blinkCnt == BLINK_LAST) ? '0 : blinkCnt + 1'b1;
  end
  assign ledOn = strobes.nocRun && ledArmed && (blinkCnt < BLINK_HALF);

  // SCR request period
  logic [SCR_W-1:0] scrCnt;
  always_ff @(posedge clk) begin
    if (!rstN || !strobes.nocRun) begin
      scrCnt <= '0;
      scrDue <= 1'b0;
    end else begin
      scrDue <= 1'b0;
      if (tick1ms) begin
        if (scrCnt == SCR_LAST) begin
          scrCnt <= '0;
          scrDue <= 1'b1;
        end else begin
          scrCnt <= scrCnt + 1'b1;
        end
      end
    end
  end

  // delay from recovery to self-test request
  logic [DLY_W-1:0] delayCnt;
  always_ff @(posedge clk) begin
    if (!rstN || !strobes.delayRun)        delayCnt <= '0;
    else if (tick1ms && delayCnt != DLY_END) delayCnt <= delayCnt + 1'b1;
  end
  assign delayDone = (delayCnt == DLY_END);

  p_age_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    (edgeAge == AGE_MAX) |=> (phaseRise || edgeAge == AGE_MAX) || $past(phaseRise));
  p_due_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    scrDue |=> !scrDue);
endmodule

// File: rtl/plm_control.sv
module plm_control
  import plm_pkg::*;
#(
  parameter int FAIL_LIMIT = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        phaseRise,
  input  logic        ageExpired,
  input  logic        scrDue,
  input  logic        delayDone,
  input  logic        zcStrobe,
  input  logic        stDone,
  input  logic        stPass,
  output plmStrobes_t strobes,
  output logic        noClock,
  output logic        scrGate,
  output logic        stReq,
  output logic        stEol
);
  localparam int FAIL_W = $clog2(FAIL_LIMIT + 1);
  localparam logic [FAIL_W-1:0] FAIL_LAST = FAIL_W'(FAIL_LIMIT - 1);

  plmState_t   state, stateNext;
  logic        pending;
  logic        posHalf, scrArmed, awaitResult;
  logic [FAIL_W-1:0] failCnt;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_NORMAL:  if (ageExpired) stateNext = ST_NOCLK;
      ST_NOCLK:   if (phaseRise && pending && !ageExpired) stateNext = ST_RESTART;
      ST_RESTART: if (ageExpired) stateNext = ST_NOCLK;
                  else if (delayDone) stateNext = ST_NORMAL;
      default:    stateNext = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_NORMAL;
      pending <= 1'b0;
    end else begin
      state <= stateNext;
      if (state != ST_NOCLK)  pending <= 1'b0;
      else if (phaseRise)     pending <= 1'b1;
    end
  end

  assign noClock          = (state == ST_NOCLK);
  assign strobes.nocRun   = (state == ST_NOCLK);
  assign strobes.delayRun = (state == ST_RESTART);

  // half-cycle tracking and SCR gate while the phase input is lost
  always_ff @(posedge clk) begin
    if (!rstN || stateNext != ST_NOCLK || state != ST_NOCLK) begin
      posHalf  <= 1'b0;
      scrArmed <= 1'b0;
      scrGate  <= 1'b0;
    end else begin
      if (scrDue) scrArmed <= 1'b1;
      if (zcStrobe) begin
        posHalf <= ~posHalf;
        if (!posHalf && (scrArmed || scrDue)) begin
          scrGate  <= 1'b1;
          scrArmed <= 1'b0;
        end else begin
          scrGate <= 1'b0;
        end
      end
    end
  end

  // self-test request and consecutive-failure tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stReq       <= 1'b0;
      awaitResult <= 1'b0;
      failCnt     <= '0;
      stEol       <= 1'b0;
    end else begin
      stReq <= 1'b0;
      if (state == ST_RESTART && stateNext == ST_NORMAL) begin
        stReq       <= 1'b1;
        awaitResult <= 1'b1;
      end else if (awaitResult && stDone) begin
        awaitResult <= 1'b0;
        if (stPass) begin
          failCnt <= '0;
        end else begin
          if (failCnt != FAIL_LAST + 1'b1) failCnt <= failCnt + 1'b1;
          if (failCnt >= FAIL_LAST)        stEol   <= 1'b1;
        end
      end
    end
  end

  p_enter_on_timeout_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(noClock) |-> $past(ageExpired));
  p_scr_in_noclk_r4: assert property (@(posedge clk) disable iff (!rstN)
    scrGate |-> noClock);
  p_gate_on_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(scrGate) |-> $past(zcStrobe));
  p_exit_on_edge_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(noClock) |-> $past(phaseRise));
  p_streq_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    stReq |=> !stReq);
  p_eol_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    stEol |=> stEol);
endmodule

// File: rtl/phase_loss_monitor.sv
module phase_loss_monitor
  import plm_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int TIMEOUT_MS    = 32,
  parameter int LED_DELAY_MS  = 150,
  parameter int BLINK_HALF_MS = 125,
  parameter int SCR_PERIOD_MS = 4000,
  parameter int RESTART_MS    = 75,
  parameter int FAIL_LIMIT    = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick1ms,
  input  logic phaseIn,
  input  logic zcStrobe,
  input  logic stDone,
  input  logic stPass,
  output logic noClock,
  output logic ledOn,
  output logic scrGate,
  output logic stReq,
  output logic stEol
);
  plmStrobes_t strobes;
  logic phaseRise, ageExpired, scrDue, delayDone;

  plm_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .TIMEOUT_MS(TIMEOUT_MS), .LED_DELAY_MS(LED_DELAY_MS),
    .BLINK_HALF_MS(BLINK_HALF_MS), .SCR_PERIOD_MS(SCR_PERIOD_MS), .RESTART_MS(RESTART_MS)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .tick1ms(tick1ms), .phaseIn(phaseIn), .strobes(strobes),
    .phaseRise(phaseRise), .ageExpired(ageExpired), .scrDue(scrDue),
    .delayDone(delayDone), .ledOn(ledOn)
  );

  plm_control #(.FAIL_LIMIT(FAIL_LIMIT)) u_control (
    .clk(clk), .rstN(rstN), .phaseRise(phaseRise), .ageExpired(ageExpired),
    .scrDue(scrDue), .delayDone(delayDone), .zcStrobe(zcStrobe), .stDone(stDone),
    .stPass(stPass), .strobes(strobes), .noClock(noClock), .scrGate(scrGate),
    .stReq(stReq), .stEol(stEol)
  );

  p_led_in_noclk_r3: assert property (@(posedge clk) disable iff (!rstN)
    ledOn |-> noClock);
endmodule

// File: tb/phase_loss_monitor_tb.sv
module phase_loss_monitor_tb;
  logic clk = 1'b0;
  logic rstN, tick1ms, zcStrobe, stDone, stPass;
  logic phaseAuto, phaseMan, phaseRun;
  logic noClock, ledOn, scrGate, stReq, stEol;
  int   errors = 0;
  int   checks = 0;
  bit   finished = 0;

  always #5 clk = ~clk;

  phase_loss_monitor u_dut (
    .clk(clk), .rstN(rstN), .tick1ms(tick1ms), .phaseIn(phaseAuto | phaseMan),
    .zcStrobe(zcStrobe), .stDone(stDone), .stPass(stPass), .noClock(noClock),
    .ledOn(ledOn), .scrGate(scrGate), .stReq(stReq), .stEol(stEol)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitMs(input int ms);
    repeat (ms * 4) @(negedge clk);
  endtask

  // 1 ms = 4 cycles
  initial begin
    tick1ms = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      tick1ms = 1'b1;
      @(negedge clk);
      tick1ms = 1'b0;
    end
  end

  // zero-cross strobe every 40 cycles (10 ms)
  initial begin
    zcStrobe = 1'b0;
    forever begin
      repeat (39) @(negedge clk);
      zcStrobe = 1'b1;
      @(negedge clk);
      zcStrobe = 1'b0;
    end
  end

  // free-running phase, 16 ms period
  initial begin
    phaseAuto = 1'b0;
    forever begin
      @(negedge clk);
      if (phaseRun) begin
        phaseAuto = 1'b1;
        waitMs(8);
        phaseAuto = 1'b0;
        waitMs(8);
      end
    end
  end

  task automatic doReset();
    rstN = 1'b0; phaseRun = 1'b0; phaseMan = 1'b0; stDone = 1'b0; stPass = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitNoClock(input string req);
    int n = 0;
    while (!noClock && n < 400) begin @(negedge clk); n++; end
    check(noClock == 1'b1, req, noClock, 1);
  endtask

  task automatic manPulse();
    phaseMan = 1'b1; waitMs(2); phaseMan = 1'b0;
  endtask

  // raise a qualifying edge, then measure the delay from exit to stReq
  task automatic exitAndMeasure();
    int n = 0;
    int d = 0;
    phaseMan = 1'b1;
    while (noClock && n < 40) begin @(negedge clk); n++; end
    check(noClock == 1'b0, "R5 second edge clears", noClock, 0);
    check(ledOn == 1'b0 && scrGate == 1'b0, "R5 outputs low after clear", {ledOn, scrGate}, 0);
    phaseRun = 1'b1;
    while (!stReq && d < 600) begin
      @(negedge clk); d++;
      if (d == 8) phaseMan = 1'b0;
    end
    phaseMan = 1'b0;
    check(d >= 292 && d <= 308, "R6 request delay cycles", d, 300);
    @(negedge clk);
    check(stReq == 1'b0, "R6 request one cycle", stReq, 0);
  endtask

  task automatic respond(input bit pass);
    repeat (4) @(negedge clk);
    stDone = 1'b1; stPass = pass;
    @(negedge clk);
    stDone = 1'b0; stPass = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic doRound(input bit pass);
    phaseRun = 1'b0;
    waitNoClock("R2 loss entered");
    manPulse();
    waitMs(6);
    exitAndMeasure();
    respond(pass);
  endtask

  task automatic testReset();
    doReset();
    @(negedge clk);
    check({noClock, ledOn, scrGate, stReq, stEol} == 5'b0, "R1 reset outputs",
          {noClock, ledOn, scrGate, stReq, stEol}, 0);
  endtask

  task automatic testTimeoutBoundary();
    waitMs(30);
    check(noClock == 1'b0, "R2 still clear at 30 ms", noClock, 0);
    waitMs(6);
    check(noClock == 1'b1, "R2 alarm at 36 ms", noClock, 1);
  endtask

  // LED sample points (ms after entry) and SCR gate count/width
  task automatic testCadence();
    int rises = 0;
    int high = 0;
    int first = 0;
    bit prev = 1'b0;
    for (int c = 1; c <= 34400; c++) begin
      @(negedge clk);
      if (c == 400)  check(ledOn == 1'b0, "R3 dark at 100 ms", ledOn, 0);
      if (c == 640)  check(ledOn == 1'b1, "R3 lit at 160 ms", ledOn, 1);
      if (c == 1040) check(ledOn == 1'b1, "R3 lit at 260 ms", ledOn, 1);
      if (c == 1200) check(ledOn == 1'b0, "R3 dark at 300 ms", ledOn, 0);
      if (c == 1680) check(ledOn == 1'b1, "R3 lit at 420 ms", ledOn, 1);
      if (scrGate) high++;
      if (scrGate && !prev) begin
        rises++;
        if (rises == 1) first = c;
      end
      prev = scrGate;
    end
    check(rises == 2, "R4 gate count in 8.6 s", rises, 2);
    check(first >= 16000 && first <= 16100, "R4 first gate cycle", first, 16000);
    check(high == 80, "R4 gate width total", high, 80);
    check(noClock == 1'b1, "R4 still no-clock", noClock, 1);
  endtask

  task automatic testGlitch();
    manPulse();
    waitMs(40);
    check(noClock == 1'b1, "R5 lone edge ignored", noClock, 1);
    manPulse();
    waitMs(8);
    check(noClock == 1'b1, "R5 late second edge ignored", noClock, 1);
    exitAndMeasure();
    respond(1'b1);
  endtask

  task automatic testNormalRun();
    int gates = 0;
    int alarms = 0;
    for (int c = 0; c < 1200; c++) begin
      @(negedge clk);
      if (scrGate) gates++;
      if (noClock) alarms++;
    end
    check(gates == 0, "R9 strobes ignored when phase present", gates, 0);
    check(alarms == 0, "R2 no alarm with 16 ms edges", alarms, 0);
  endtask

  task automatic testPassClears();
    doReset();
    phaseRun = 1'b1;
    waitMs(20);
    for (int i = 0; i < 3; i++) doRound(1'b0);
    doRound(1'b1);
    doRound(1'b0);
    check(stEol == 1'b0, "R8 pass restarts failure count", stEol, 0);
  endtask

  task automatic testEol();
    doReset();
    phaseRun = 1'b1;
    waitMs(20);
    for (int i = 0; i < 3; i++) doRound(1'b0);
    check(stEol == 1'b0, "R7 three failures not enough", stEol, 0);
    doRound(1'b0);
    check(stEol == 1'b1, "R7 fourth failure sets flag", stEol, 1);
    doRound(1'b1);
    check(stEol == 1'b1, "R7 flag sticky after pass", stEol, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    testReset();
    testTimeoutBoundary();
    testCadence();
    testGlitch();
    testNormalRun();
    testPassClears();
    testEol();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule